// File: doc/BRIEF.md
# Configurable Registered Address Buffer

This block is a clocked register stage for the command and address path of a memory module. On each rising clock edge it captures a bank of input bits and drives them from registers onto a wider output bank. Two static configuration pins give it its shape. In straight mode, 25 inputs map one-to-one onto 25 outputs. In fan-out mode, 14 inputs are captured and each one drives two outputs. Fan-out mode has two placement variants: a split layout and an interleaved layout.

Two active-low select inputs act as a power gate. The registers load only when at least one select is low. When both are high, the outputs keep their present values. An active-low asynchronous reset clears every register at any point in the clock cycle, and this forces all outputs low. Reset overrides the select gating. The configuration pins are meant to change only while reset is held.

Top module: `cfg_reg_buffer`

## Requirements
- R1: With `fanSel` low, at each loading edge `dataOut[i]` takes `dataIn[i]` for i in 0..24, and `dataOut[27:25]` are driven 0.
- R2: With `fanSel` high and `mapSel` low (split layout), captured input bit i (i in 0..13) drives both `dataOut[i]` and `dataOut[i+14]`.
- R3: With `fanSel` high and `mapSel` high (interleaved layout), captured input bit i (i in 0..13) drives both `dataOut[2i]` and `dataOut[2i+1]`.
- R4: In fan-out mode, `dataIn[24:14]` have no effect on any output.
- R5: Inputs are captured only at the rising edge of `clk`. Outputs change only after that edge and stay steady until the next one.
- R6: When `selAN` and `selBN` are both high at a rising edge, every output keeps its previous value.
- R7: When `selAN` or `selBN` is low at a rising edge, the outputs load the new data at that same edge.
- R8: While `rstN` is low, all outputs are 0. This takes effect at once, in the middle of a clock cycle, and whatever the select inputs are.
- R9: After `rstN` rises, the outputs stay 0 on every cycle for as long as `dataIn` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fanSel | input | 1 | 0 = straight 25-bit mode, 1 = 14-bit fan-out mode |
| mapSel | input | 1 | Fan-out layout: 0 = split, 1 = interleaved |
| selAN | input | 1 | First select, active low |
| selBN | input | 1 | Second select, active low |
| dataIn | input | 25 | Input bank |
| dataOut | output | 28 | Registered output bank |

## Verification
Reset and select gating can land in the same cycle. So can gating and a new data word. The bench asserts reset in the middle of a cycle while both selects are high and non-zero data is loaded, and it expects every output to drop to 0 before the next edge. Random select pairs mixed with random data make held edges and loading edges alternate in every configuration. Each edge is judged against a bench model that updates only when at least one select is low.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef struct packed {
    logic load;
    logic fanOut;
    logic mapB;
  } crb_strobe_t;
endpackage

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
(
  input  logic        fanSel,
  input  logic        mapSel,
  input  logic        selAN,
  input  logic        selBN,
  output crb_strobe_t strb
);
  always_comb begin
    strb.load   = ~(selAN & selBN);
    strb.fanOut = fanSel;
    strb.mapB   = fanSel & mapSel;
  end
endmodule

// File: rtl/crb_datapath.sv
module crb_datapath
  import crb_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int OUT_W    = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  crb_strobe_t       strb,
  input  logic [WIDE_W-1:0] dataIn,
  output logic [OUT_W-1:0]  dataOut
);
  logic [WIDE_W-1:0] capReg;
  logic [OUT_W-1:0]  wideOut, splitOut, leaveOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          capReg <= '0;
    else if (strb.load) capReg <= dataIn;
  end

  always_comb begin
    wideOut = '0;
    wideOut[WIDE_W-1:0] = capReg;
  end

  always_comb begin
    splitOut = '0;
    leaveOut = '0;
    for (int i = 0; i < NARROW_W; i++) begin
      splitOut[i]            = capReg[i];
      splitOut[i + NARROW_W] = capReg[i];
      leaveOut[2*i]          = capReg[i];
      leaveOut[2*i + 1]      = capReg[i];
    end
  end

  always_comb begin
    if (!strb.fanOut)   dataOut = wideOut;
    else if (strb.mapB) dataOut = leaveOut;
    else                dataOut = splitOut;
  end

  // R6: a held edge leaves the register untouched
  a_r6_hold_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(capReg));

  // R7: a loading edge captures the input word
  a_r7_load_when_selected: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> capReg == $past(dataIn));

  // R2: split layout duplicates the low half onto the high half
  a_r2_split_copies: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fanOut && !strb.mapB) |-> dataOut[NARROW_W-1:0] == dataOut[2*NARROW_W-1:NARROW_W]);

  // R1: straight mode leaves the spare outputs low
  a_r1_spare_low: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fanOut |-> dataOut[OUT_W-1:WIDE_W] == '0);
endmodule

// File: rtl/cfg_reg_buffer.sv
module cfg_reg_buffer
  import crb_pkg::*;
#(
  parameter  int WIDE_W   = 25,
  parameter  int NARROW_W = 14,
  localparam int OUT_W    = (WIDE_W > 2*NARROW_W) ? WIDE_W : 2*NARROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fanSel,
  input  logic              mapSel,
  input  logic              selAN,
  input  logic              selBN,
  input  logic [WIDE_W-1:0] dataIn,
  output logic [OUT_W-1:0]  dataOut
);
  crb_strobe_t strb;

  crb_ctrl i_ctrl (
    .fanSel (fanSel),
    .mapSel (mapSel),
    .selAN  (selAN),
    .selBN  (selBN),
    .strb   (strb)
  );

  crb_datapath #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W),
    .OUT_W    (OUT_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  // R9: zero input words keep zero outputs after reset release
  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dataIn) == '0 && $past(dataOut) == '0) |-> dataOut == '0);

  // R3: interleaved layout drives each output pair equally
  a_r3_pairs_match: assert property (@(posedge clk) disable iff (!rstN)
    (fanSel && mapSel) |-> (dataOut[0] == dataOut[1] && dataOut[2*NARROW_W-2] == dataOut[2*NARROW_W-1]));
endmodule

// File: tb/test_cfg_reg_buffer.sv
`timescale 1ns/1ps
module test_cfg_reg_buffer;
  localparam int WW = 25;
  localparam int NW = 14;
  localparam int OW = 28;

  logic          clk = 0;
  logic          rstN = 0;
  logic          fanSel = 0, mapSel = 0, selAN = 0, selBN = 0;
  logic [WW-1:0] dataIn = '0;
  logic [OW-1:0] dataOut;
  logic [WW-1:0] model = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_reg_buffer i_cfg_reg_buffer (
    .clk(clk), .rstN(rstN), .fanSel(fanSel), .mapSel(mapSel),
    .selAN(selAN), .selBN(selBN), .dataIn(dataIn), .dataOut(dataOut));

  function automatic logic [OW-1:0] expOut(logic [WW-1:0] c, logic f, logic m);
    logic [OW-1:0] r = '0;
    if (!f) r[WW-1:0] = c;
    else for (int i = 0; i < NW; i++) begin
      if (m) begin r[2*i] = c[i]; r[2*i+1] = c[i]; end
      else   begin r[i] = c[i]; r[i+NW] = c[i]; end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string modeTag();
    return !fanSel ? "R1" : (mapSel ? "R3" : "R2");
  endfunction

  task automatic step(logic [WW-1:0] d, logic a, logic b, string tag);
    @(negedge clk);
    dataIn = d; selAN = a; selBN = b;
    @(posedge clk);
    if (!(a & b)) model = d;
    #1 check(tag, dataOut, expOut(model, fanSel, mapSel));
    #3 check({tag, " R5"}, dataOut, expOut(model, fanSel, mapSel));
  endtask

  task automatic setMode(logic f, logic m);
    @(negedge clk);
    rstN = 0; model = '0;
    #1 check("R8", dataOut, '0);
    fanSel = f; mapSel = m; dataIn = '0; selAN = 0; selBN = 0;
    @(negedge clk);
    rstN = 1;
    for (int k = 0; k < 3; k++) step('0, 0, 0, "R9");
  endtask

  initial begin
    logic [WW-1:0] x;
    repeat (3) @(posedge clk);
    #1 check("R8 reset state", dataOut, '0);
    for (int md = 0; md < 3; md++) begin
      setMode(md != 0, md == 2);
      step(25'h1AAAAAA, 0, 0, modeTag());
      step(25'h0155555, 1, 0, modeTag());
      step(25'h1FFFFFF, 0, 1, "R7");
      step(25'h0000001, 1, 1, "R6");
      step(25'h0123456, 1, 1, "R6");
      if (fanSel) begin
        x = 25'h0002A5C;
        step(x, 0, 0, modeTag());
        step(x ^ 25'h1FFC000, 0, 0, "R4");
      end
      for (int k = 0; k < 150; k++) begin
        logic a, b;
        a = $urandom(); b = $urandom();
        step(WW'($urandom()), a, b, (a & b) ? "R6" : modeTag());
      end
    end
    // reset in the middle of a cycle while both selects are high
    setMode(1, 0);
    step(25'h0003FFF, 0, 0, "R2");
    @(negedge clk); selAN = 1; selBN = 1; dataIn = 25'h1FFFFFF;
    @(posedge clk); #2 rstN = 0; model = '0;
    #1 check("R8 mid-cycle", dataOut, '0);
    @(posedge clk); #1 check("R8 priority", dataOut, '0);
    @(negedge clk); dataIn = '0; selAN = 0; selBN = 0; rstN = 1;
    for (int k = 0; k < 4; k++) step('0, 0, 0, "R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule